// File: doc/BRIEF.md
# Dual-Port Double-Rate Burst SRAM Model

This block is a synthesizable model of a synchronous SRAM with separate data buses for reading and writing. One address bus is shared by both ports in time. A free-running system clock runs at twice the word rate. Its edges alternate between two phases. The K phase stands for the primary clock edge and the K-bar phase stands for the complementary edge. Both ports can work in every K period. Each has its own active-low select, and no bus turnaround is ever needed.

Each address holds two words, and each access moves both of them as a two-beat burst. Reads take their address on the K phase. Writes take theirs on the K-bar phase, and the write data follows on the next two edges. A pending-write register keeps reads coherent, so a read sees a write to the same address that has not yet reached the array.

Top module: `qdr_burst_sram`

## Requirements
- R1: A read and a write to different addresses may be issued in the same K period, and both complete with no effect on each other.
- R2: Edges are counted from 0 at the first rising clock after reset release. Even edges are K edges, and `addr_i` and `rd_sel_ni` are sampled there. Odd edges are K-bar edges, and `addr_i` and `wr_sel_ni` are sampled there.
- R3: For a write whose address is sampled at edge w, word 0 is taken from `wdata_i` at edge w+1 and word 1 at edge w+2. The location is committed at edge w+2.
- R4: For a read whose address is sampled at edge e, `rdata_o` shows word 0 after edge e+3 and word 1 after edge e+4.
- R5: `rvalid_o` is high after edges e+3 and e+4 of each selected read, and low otherwise.
- R6: When `rd_sel_ni` is high at a K edge, no read takes place. When `wr_sel_ni` is high at a K-bar edge, the location is left unchanged. Neither select affects the other port.
- R7: A read sampled at edge e returns the data of every write sampled at edges up to e+1, which includes a write in the same K period. It returns none of the data of a write sampled at e+3 or later.
- R8: Reset drives `rvalid_o` and `rdata_o` to 0 and drops every in-flight read and write. The array contents are kept across reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Double-rate clock. Its edges alternate between the K and K-bar phases |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Shared address: the read address on K edges, the write address on K-bar edges |
| rd_sel_ni | input | 1 | Read select, active low, sampled on K edges |
| wr_sel_ni | input | 1 | Write select, active low, sampled on K-bar edges |
| wdata_i | input | DW | Write data, one word per edge |
| rdata_o | output | DW | Registered read data, one word per edge |
| rvalid_o | output | 1 | High while `rdata_o` carries a burst word |

## Verification
The bench builds the block with an 8-bit word and a 3-bit address. With only eight locations, random traffic keeps hitting the same address from both ports, including reads and writes to one address in the same or the adjacent K period. That exercises the forwarding path and its timing limits. Placing different addresses on the two phases of each period exposes a port that samples on the wrong phase.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
  typedef enum logic {
    PH_K  = 1'b0,
    PH_KB = 1'b1
  } qdr_phase_e;
endpackage

// File: rtl/qdr_mem_array.sv
module qdr_mem_array #(
  parameter int DW = 18,
  parameter int AW = 6
) (
  input  logic            clk_i,
  input  logic            we_i,
  input  logic [AW-1:0]   waddr_i,
  input  logic [2*DW-1:0] wdata_i,
  input  logic [AW-1:0]   raddr_i,
  output logic [2*DW-1:0] rdata_o
);
  localparam int Depth = 1 << AW;

  logic [2*DW-1:0] mem_q [Depth];

  // no reset: contents survive rst_ni
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/qdr_wr_path.sv
module qdr_wr_path #(
  parameter int DW = 18,
  parameter int AW = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            k_edge_i,
  input  logic [AW-1:0]   addr_i,
  input  logic            wr_sel_ni,
  input  logic [DW-1:0]   wdata_i,
  output logic            pend_v_o,
  output logic [AW-1:0]   pend_addr_o,
  output logic [DW-1:0]   pend_w0_o,
  output logic            we_o,
  output logic [AW-1:0]   we_addr_o,
  output logic [2*DW-1:0] we_data_o
);
  logic          wa_v_q;
  logic [AW-1:0] wa_q;
  logic          pv_q;
  logic [AW-1:0] pa_q;
  logic [DW-1:0] pw0_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wa_v_q <= 1'b0;
      wa_q   <= '0;
      pv_q   <= 1'b0;
      pa_q   <= '0;
      pw0_q  <= '0;
    end else if (k_edge_i) begin
      pv_q  <= wa_v_q;
      pa_q  <= wa_q;
      pw0_q <= wdata_i;
    end else begin
      wa_v_q <= !wr_sel_ni;
      wa_q   <= addr_i;
      pv_q   <= 1'b0;
    end
  end

  // commit on the K-bar edge that brings word 1
  assign we_o        = pv_q && !k_edge_i;
  assign we_addr_o   = pa_q;
  assign we_data_o   = {wdata_i, pw0_q};
  assign pend_v_o    = pv_q;
  assign pend_addr_o = pa_q;
  assign pend_w0_o   = pw0_q;

  p_commit_tracks_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> ($past(wa_v_q) && we_addr_o == $past(wa_q)));
endmodule

// File: rtl/qdr_rd_path.sv
module qdr_rd_path #(
  parameter int DW = 18,
  parameter int AW = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            k_edge_i,
  input  logic [AW-1:0]   addr_i,
  input  logic            rd_sel_ni,
  input  logic            pend_v_i,
  input  logic [AW-1:0]   pend_addr_i,
  input  logic [DW-1:0]   pend_w0_i,
  input  logic [2*DW-1:0] arr_data_i,
  output logic [AW-1:0]   arr_addr_o,
  output logic [DW-1:0]   rdata_o,
  output logic            rvalid_o
);
  logic          a_v_q, b_v_q;
  logic [AW-1:0] a_addr_q, b_addr_q;
  logic          fwd_hit;

  assign arr_addr_o = b_addr_q;
  assign fwd_hit    = pend_v_i && (pend_addr_i == b_addr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_v_q    <= 1'b0;
      a_addr_q <= '0;
      b_v_q    <= 1'b0;
      b_addr_q <= '0;
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else if (k_edge_i) begin
      a_v_q    <= !rd_sel_ni;
      a_addr_q <= addr_i;
      b_v_q    <= a_v_q;
      b_addr_q <= a_addr_q;
      rvalid_o <= b_v_q;
      rdata_o  <= arr_data_i[2*DW-1:DW];
    end else begin
      rvalid_o <= b_v_q;
      // same-period write: word 0 only lives in the pending register
      rdata_o  <= fwd_hit ? pend_w0_i : arr_data_i[DW-1:0];
    end
  end

  p_fwd_on_kbar_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_v_q && fwd_hit) |-> !k_edge_i);
endmodule

// File: rtl/qdr_burst_sram.sv
module qdr_burst_sram
  import qdr_pkg::*;
#(
  parameter int DW = 18,
  parameter int AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          rd_sel_ni,
  input  logic          wr_sel_ni,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);
  qdr_phase_e      ph_q;
  logic            k_edge;
  logic            pend_v;
  logic [AW-1:0]   pend_addr;
  logic [DW-1:0]   pend_w0;
  logic            we;
  logic [AW-1:0]   we_addr;
  logic [2*DW-1:0] we_data;
  logic [AW-1:0]   arr_addr;
  logic [2*DW-1:0] arr_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= PH_K;
    else         ph_q <= (ph_q == PH_K) ? PH_KB : PH_K;
  end

  assign k_edge = (ph_q == PH_K);

  qdr_wr_path #(.DW(DW), .AW(AW)) u_wr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .k_edge_i   (k_edge),
    .addr_i     (addr_i),
    .wr_sel_ni  (wr_sel_ni),
    .wdata_i    (wdata_i),
    .pend_v_o   (pend_v),
    .pend_addr_o(pend_addr),
    .pend_w0_o  (pend_w0),
    .we_o       (we),
    .we_addr_o  (we_addr),
    .we_data_o  (we_data)
  );

  qdr_mem_array #(.DW(DW), .AW(AW)) u_mem (
    .clk_i  (clk_i),
    .we_i   (we),
    .waddr_i(we_addr),
    .wdata_i(we_data),
    .raddr_i(arr_addr),
    .rdata_o(arr_data)
  );

  qdr_rd_path #(.DW(DW), .AW(AW)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .k_edge_i   (k_edge),
    .addr_i     (addr_i),
    .rd_sel_ni  (rd_sel_ni),
    .pend_v_i   (pend_v),
    .pend_addr_i(pend_addr),
    .pend_w0_i  (pend_w0),
    .arr_data_i (arr_data),
    .arr_addr_o (arr_addr),
    .rdata_o    (rdata_o),
    .rvalid_o   (rvalid_o)
  );

  p_burst_starts_kbar_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rvalid_o) |-> (ph_q == PH_K));

  p_burst_pair_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && ph_q == PH_K) |=> rvalid_o);

  p_read_needs_sel_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && ph_q == PH_K) |-> !$past(rd_sel_ni, 4));
endmodule

// File: tb/qdr_burst_sram_tb.sv
module qdr_burst_sram_tb;
  localparam int  DW = 8;
  localparam int  AW = 3;
  localparam int  DEPTH = 1 << AW;
  localparam time CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          rd_sel_n = 1'b1;
  logic          wr_sel_n = 1'b1;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          rvalid;

  int total = 0;
  int bad = 0;

  qdr_burst_sram #(.DW(DW), .AW(AW)) u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .addr_i   (addr),
    .rd_sel_ni(rd_sel_n),
    .wr_sel_ni(wr_sel_n),
    .wdata_i  (wdata),
    .rdata_o  (rdata),
    .rvalid_o (rvalid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // reference model: edge-indexed, word-granular memory
  int            n = 0;
  bit            live = 0;
  logic [DW-1:0] mm0 [DEPTH];
  logic [DW-1:0] mm1 [DEPTH];
  bit            k0 [DEPTH];
  bit            k1 [DEPTH];
  bit            rh_v [8];
  logic [AW-1:0] rh_a [8];
  string         rh_t [8];
  bit            m_wa_v = 0, m_w0_v = 0;
  logic [AW-1:0] m_wa = '0, m_w0a = '0;
  bit            exp_v = 0, exp_k = 0;
  logic [DW-1:0] exp_d = '0;
  string         exp_t = "";
  string         cur_tag = "R4 read";

  always @(posedge clk) begin
    if (!rst_n) begin
      n = 0; live = 0; exp_v = 0;
      m_wa_v = 0; m_w0_v = 0;
      for (int i = 0; i < 8; i++) rh_v[i] = 0;
    end else begin
      exp_v = 0; exp_k = 0; live = 1;
      if (n % 2 == 0) begin
        if (m_wa_v) begin
          mm0[m_wa] = wdata; k0[m_wa] = 1; m_w0_v = 1; m_w0a = m_wa; m_wa_v = 0;
        end
        rh_v[n % 8] = !rd_sel_n; rh_a[n % 8] = addr; rh_t[n % 8] = cur_tag;
        if (n >= 4 && rh_v[(n-4) % 8]) begin
          exp_v = 1; exp_d = mm1[rh_a[(n-4) % 8]]; exp_k = k1[rh_a[(n-4) % 8]];
          exp_t = {rh_t[(n-4) % 8], " word1"};
        end
      end else begin
        if (m_w0_v) begin
          mm1[m_w0a] = wdata; k1[m_w0a] = 1; m_w0_v = 0;
        end
        m_wa_v = !wr_sel_n; m_wa = addr;
        if (n >= 3 && rh_v[(n-3) % 8]) begin
          exp_v = 1; exp_d = mm0[rh_a[(n-3) % 8]]; exp_k = k0[rh_a[(n-3) % 8]];
          exp_t = {rh_t[(n-3) % 8], " word0"};
        end
      end
      n++;
    end
  end

  always @(negedge clk) begin
    if (rst_n && live) begin
      chk(rvalid == exp_v, "R5 rvalid", int'(rvalid), int'(exp_v));
      if (exp_v && exp_k) chk(rdata == exp_d, exp_t, int'(rdata), int'(exp_d));
    end
  end

  // one K period; d0/d1 are carried out in the following period
  logic [DW-1:0] nx0 = '0, nx1 = '0;
  task automatic kcyc(bit rd, logic [AW-1:0] ra, bit wr, logic [AW-1:0] wa,
                      logic [DW-1:0] d0, logic [DW-1:0] d1);
    rd_sel_n = !rd; addr = ra; wdata = nx0;
    @(negedge clk);
    wr_sel_n = !wr; addr = wa; wdata = nx1;
    @(negedge clk);
    nx0 = d0; nx1 = d1;
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) kcyc(0, '0, 0, '1, 8'h5A, 8'hA5);
  endtask

  logic [15:0] lf = 16'hACE1;

  initial begin
    for (int i = 0; i < DEPTH; i++) begin k0[i] = 0; k1[i] = 0; end
    repeat (3) @(negedge clk);
    chk(rvalid == 1'b0, "R8 reset rvalid", int'(rvalid), 0);
    chk(rdata == '0, "R8 reset rdata", int'(rdata), 0);
    #1 rst_n = 1'b1;

    // fill
    for (int a = 0; a < DEPTH; a++) kcyc(0, '0, 1, AW'(a), DW'(8'hA0 + a), DW'(8'h50 + a));
    idle(1);
    cur_tag = "R4 read-back";
    for (int a = 0; a < DEPTH; a++) kcyc(1, AW'(a), 0, '0, '0, '0);
    idle(3);

    // concurrent traffic on both ports
    cur_tag = "R1 concurrent";
    for (int a = 0; a < DEPTH; a++)
      kcyc(1, AW'(a), 1, AW'(DEPTH-1-a), DW'(8'hC0 + a), DW'(8'h30 + a));
    idle(3);

    // same K period forward, and a later write must stay invisible
    cur_tag = "R7 same-period";
    kcyc(1, 3'd3, 1, 3'd3, 8'h3C, 8'hC3);
    cur_tag = "R7 no-early";
    kcyc(1, 3'd5, 0, '0, '0, '0);
    kcyc(0, '0, 1, 3'd5, 8'h77, 8'h88);
    cur_tag = "R7 after";
    kcyc(1, 3'd5, 0, '0, '0, '0);
    idle(3);

    // deselected write leaves location; deselected read gives no valid
    cur_tag = "R6 deselect";
    kcyc(0, 3'd2, 0, 3'd2, 8'hEE, 8'hDD);
    kcyc(0, 3'd2, 0, 3'd2, 8'hBB, 8'hCC);
    kcyc(1, 3'd2, 0, '0, '0, '0);
    idle(3);

    // random mix
    cur_tag = "R2 random";
    for (int i = 0; i < 300; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      kcyc(lf[0], lf[3:1], lf[4], lf[7:5], lf[15:8], lf[11:4]);
    end
    idle(3);

    // reset keeps array
    #1 rst_n = 1'b0; live = 0;
    repeat (2) @(negedge clk);
    chk(rvalid == 1'b0, "R8 mid reset rvalid", int'(rvalid), 0);
    chk(rdata == '0, "R8 mid reset rdata", int'(rdata), 0);
    #1 rst_n = 1'b1;
    cur_tag = "R8 retained";
    for (int a = 0; a < DEPTH; a++) kcyc(1, AW'(a), 0, '0, '0, '0);
    idle(3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule